// File: doc/BRIEF.md
# JTAG Configuration Register Read Sequencer

This block is a JTAG master that reads one 32-bit configuration register from a target device. It drives TCK, TMS and TDI and samples TDO. After a start pulse it resets the target's TAP and loads the configuration-input instruction. It then shifts a synchronisation word, the caller's read packet header and two no-op flush words through the data register. Next it loads the configuration-output instruction and shifts the register value back in. It finishes by walking the TAP back to Test-Logic-Reset.

TCK is made from the system clock by an enable counter, so one TCK period is always an even number of system cycles. TMS and TDI are updated on falling TCK edges, and TDO is captured on rising ones. Instructions go out LSB first and data words MSB first. The final bit of every shift pass is sent with TMS high, so the TAP leaves the shift state on that bit. A caller holds the header for a single cycle with the start pulse and waits for the one-cycle done flag. It then reads the result word, which holds its value until the next transaction.

Top module: `jtag_cfg_reg_reader`

## Requirements
- R1: TCK is low whenever no transaction is running. During a transaction its high and low phases each last exactly TCK_HALF system clock cycles.
- R2: TMS and TDI change only while TCK is low, that is, on a falling TCK edge or in the cycle that accepts start. TDO is sampled on the rising TCK edge.
- R3: The first five TCK cycles carry TMS=1, which resets the TAP. The next five carry TMS 0,1,1,0,0, which leads to Shift-IR.
- R4: Each instruction is 6 bits wide and shifted LSB first. The first five bits go out with TMS=0 and the sixth with TMS=1. The first instruction is configuration-input, code 0x05 (000101). The second is configuration-output, code 0x04 (000100).
- R5: After each instruction, TMS 1,1,0,0 leads from Exit1-IR to Shift-DR.
- R6: The write pass shifts 128 bits MSB first, in this order: 0xAA995566, the header, then 0x20000000 twice. TMS is 1 only on the last of the 128 bits.
- R7: After the write pass, TMS 1,1,1,0,0 leads to Shift-IR. After the second instruction, a 32-bit read pass follows with TDI low and TMS=1 on its last bit. The TDO bits are collected MSB first into result_o.
- R8: The transaction ends with five TCK cycles of TMS=1, which leaves the target TAP in Test-Logic-Reset.
- R9: done_o is high for exactly one system cycle after the last TCK cycle. From then until the next start, result_o holds the register value.
- R10: header_i is captured in the cycle that accepts start. A start pulse or header change during a running transaction has no effect.
- R11: One transaction is exactly 200 TCK cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transaction when idle |
| header_i | input | 32 | Read packet header, captured at start |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |
| result_o | output | 32 | Register value read back |
| done_o | output | 1 | One-cycle end-of-transaction flag |

## Verification
The embedded assertions check these properties on every cycle:
- TMS moves only on a falling TCK edge or at start.
- TCK stays low while idle.
- done never lasts two cycles.
- The latched header and the result word change only when their enables allow.
- The step walker advances only on rising TCK edges.

The exact TMS walk through the TAP states, the bit order of each pass and the instruction codes can only be shown by the bench's scenarios. The bench runs each transaction against a behavioural TAP model, starting from several TAP states. The same applies to the words the target actually receives, the value read back and the final Test-Logic-Reset state.

// File: rtl/jcr_pkg.sv
package jcr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [WORD_W-1:0] NOOP_WORD = 32'h2000_0000;

  // order is the transaction order
  typedef enum logic [3:0] {
    PH_RESET,
    PH_TO_IR_A,
    PH_IR_A,
    PH_TO_DR_A,
    PH_DR_A,
    PH_TO_IR_B,
    PH_IR_B,
    PH_TO_DR_B,
    PH_DR_B,
    PH_RESET_END,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/jcr_tck_gen.sv
module jcr_tck_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick & ~tck_o;
  assign fall_o = tick & tck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      tck_o <= ~tck_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jcr_walk.sv
module jcr_walk
  import jcr_pkg::*;
#(
  parameter int unsigned IR_W    = 6,
  parameter int unsigned RST_LEN = 5,
  parameter int unsigned N_FLUSH = 2,
  parameter logic [IR_W-1:0] IR_IN  = 6'b000101,
  parameter logic [IR_W-1:0] IR_OUT = 6'b000100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] header_i,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              capture_o,
  output phase_e            phase_o
);
  localparam int unsigned DR_IN_LEN = (2 + N_FLUSH) * WORD_W;
  localparam int unsigned CNT_W     = $clog2(DR_IN_LEN + 1);
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned WS_W      = CNT_W - BIT_W;
  localparam int unsigned IRI_W     = (IR_W > 1) ? $clog2(IR_W) : 1;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   len;
  logic               last;
  logic [WS_W-1:0]    wsel;
  logic [BIT_W-1:0]   bpos;
  logic [WORD_W-1:0]  cur_word;
  logic [IR_W-1:0]    ir_code;

  always_comb begin
    unique case (phase_q)
      PH_RESET, PH_RESET_END:   len = CNT_W'(RST_LEN);
      PH_TO_IR_A, PH_TO_IR_B:   len = CNT_W'(5);
      PH_TO_DR_A, PH_TO_DR_B:   len = CNT_W'(4);
      PH_IR_A, PH_IR_B:         len = CNT_W'(IR_W);
      PH_DR_A:                  len = CNT_W'(DR_IN_LEN);
      PH_DR_B:                  len = CNT_W'(WORD_W);
      default:                  len = CNT_W'(1);
    endcase
  end

  assign last = (cnt_q == len - 1'b1);

  // write pass: word index from the upper count bits, MSB first within the word
  assign wsel = cnt_q[CNT_W-1:BIT_W];
  assign bpos = ~cnt_q[BIT_W-1:0];
  always_comb begin
    if (wsel == '0)              cur_word = SYNC_WORD;
    else if (wsel == WS_W'(1))   cur_word = header_i;
    else                         cur_word = NOOP_WORD;
  end

  assign ir_code = (phase_q == PH_IR_A) ? IR_IN : IR_OUT;

  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b0;
    unique case (phase_q)
      PH_TO_IR_A: tms_o = (cnt_q == CNT_W'(1)) || (cnt_q == CNT_W'(2));
      PH_TO_IR_B: tms_o = (cnt_q < CNT_W'(3));
      PH_TO_DR_A, PH_TO_DR_B: tms_o = (cnt_q < CNT_W'(2));
      PH_IR_A, PH_IR_B: begin
        tms_o = last;
        tdi_o = ir_code[cnt_q[IRI_W-1:0]];
      end
      PH_DR_A: begin
        tms_o = last;
        tdi_o = cur_word[bpos];
      end
      PH_DR_B: tms_o = last;
      default: tms_o = 1'b1;
    endcase
  end

  assign capture_o = (phase_q == PH_DR_B);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RESET;
      cnt_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_RESET;
      cnt_q   <= '0;
    end else if (step_i && phase_q != PH_DONE) begin
      if (last) begin
        phase_q <= phase_e'(phase_q + 4'd1);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R11
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_q) |-> $past(step_i || clear_i));
endmodule

// File: rtl/jcr_capture.sv
module jcr_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         tdo_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_o <= '0;
    else if (sample_i) word_o <= {word_o[W-2:0], tdo_i};
  end

  // R7
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> $past(sample_i));
endmodule

// File: rtl/jtag_cfg_reg_reader.sv
module jtag_cfg_reg_reader
  import jcr_pkg::*;
#(
  parameter int unsigned TCK_HALF = 2,
  parameter int unsigned IR_W     = 6,
  parameter int unsigned RST_LEN  = 5,
  parameter int unsigned N_FLUSH  = 2,
  parameter logic [IR_W-1:0] IR_CFG_IN  = 6'b000101,
  parameter logic [IR_W-1:0] IR_CFG_OUT = 6'b000100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] header_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o
);
  logic              busy_q;
  logic [WORD_W-1:0] hdr_q;
  logic              tms_q, tdi_q, done_q;
  logic              rise, fall, start_acc, fin;
  logic              w_tms, w_tdi, w_cap;
  phase_e            phase;

  assign start_acc = start_i & ~busy_q;
  assign fin       = fall & (phase == PH_DONE);

  jcr_tck_gen #(.HALF(TCK_HALF)) u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  jcr_walk #(
    .IR_W(IR_W), .RST_LEN(RST_LEN), .N_FLUSH(N_FLUSH),
    .IR_IN(IR_CFG_IN), .IR_OUT(IR_CFG_OUT)
  ) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (rise),
    .clear_i   (fin),
    .header_i  (hdr_q),
    .tms_o     (w_tms),
    .tdi_o     (w_tdi),
    .capture_o (w_cap),
    .phase_o   (phase)
  );

  jcr_capture #(.W(WORD_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rise & w_cap),
    .tdo_i    (tdo_i),
    .word_o   (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hdr_q  <= '0;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (start_acc) begin
        busy_q <= 1'b1;
        hdr_q  <= header_i;
        tms_q  <= w_tms;
        tdi_q  <= w_tdi;
      end else if (busy_q && fall) begin
        tms_q <= w_tms;
        tdi_q <= w_tdi;
        if (phase == PH_DONE) busy_q <= 1'b0;
      end
    end
  end

  assign tms_o  = tms_q;
  assign tdi_o  = tdi_q;
  assign done_o = done_q;

  // R2
  tms_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tms_o) |-> $past(fall || start_acc));
  // R1
  tck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !tck_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  hdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(hdr_q));
endmodule

// File: tb/jtag_cfg_reg_reader_tb_top.sv
`timescale 1ns/1ps
module jtag_cfg_reg_reader_tb_top;
  localparam int HALF = 2;
  localparam logic [31:0] SYNC = 32'hAA995566;
  localparam logic [31:0] NOOP = 32'h20000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 1'b0;
  logic [31:0] header_i = '0;
  logic        tck_o, tms_o, tdi_o, done_o;
  logic        tdo;
  logic [31:0] result_o;

  jtag_cfg_reg_reader #(.TCK_HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .header_i(header_i),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo),
    .result_o(result_o), .done_o(done_o)
  );

  // ---------------- behavioural target TAP ----------------
  typedef enum logic [3:0] {TLR, RTI, SDS, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIS, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_e;
  tap_e        st = TLR;
  tap_e        kick_state = TLR;
  logic        tap_kick = 1'b0;
  logic [5:0]  ir_sr = '0, ir_reg = 6'h09;
  logic [31:0] dr = '0, reg_val = '0;
  int          rise_n = 0, ir_n = 0, w_n = 0, dr_bits = 0;
  bit          tms_hist [0:4095];
  logic [5:0]  ir_hist  [0:63];
  logic [31:0] w_hist   [0:127];

  function automatic tap_e nxt(tap_e s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDS  : RTI;
      SDS:  return m ? SIS  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDS  : RTI;
      SIS:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck_o or posedge tap_kick) begin
    if (tap_kick) st <= kick_state;
    else begin
      if (rise_n < 4096) tms_hist[rise_n] <= tms_o;
      rise_n <= rise_n + 1;
      case (st)
        TLR:  ir_reg <= 6'h09;
        CIR:  ir_sr <= 6'b000001;
        SHIR: ir_sr <= {tdi_o, ir_sr[5:1]};
        UIR: begin
          ir_reg <= ir_sr;
          if (ir_n < 64) ir_hist[ir_n] <= ir_sr;
          ir_n <= ir_n + 1;
        end
        CDR: begin
          dr <= (ir_reg == 6'b000100) ? reg_val : 32'h0;
          dr_bits <= 0;
        end
        SHDR: begin
          dr <= {dr[30:0], tdi_o};
          if (ir_reg == 6'b000101) begin
            dr_bits <= dr_bits + 1;
            if (dr_bits % 32 == 31) begin
              if (w_n < 128) w_hist[w_n] <= {dr[30:0], tdi_o};
              w_n <= w_n + 1;
            end
          end
        end
        default: ;
      endcase
      st <= nxt(st, tms_o);
    end
  end

  always @(negedge tck_o)
    tdo <= (st == SHDR) ? dr[31] : ((st == SHIR) ? ir_sr[0] : 1'b0);

  // ---------------- pin monitors ----------------
  int   viol = 0, phase_err = 0, done_n = 0, run_len = 0;
  logic prev_tck = 1'b0, prev_tms = 1'b1, prev_tdi = 1'b0;
  bit   seen_hi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if ((tms_o !== prev_tms || tdi_o !== prev_tdi) && tck_o) viol++;
    if (tck_o == prev_tck) run_len++;
    else begin
      if ((prev_tck || seen_hi) && run_len != HALF) phase_err++;
      if (tck_o) seen_hi = 1'b1;
      run_len = 1;
    end
    if (done_o) begin done_n++; seen_hi = 1'b0; end
    prev_tck = tck_o; prev_tms = tms_o; prev_tdi = tdi_o;
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0;
  bit finished = 1'b0;
  bit exp_tms [0:199];
  int ei = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic add(bit b, int n);
    for (int k = 0; k < n; k++) begin exp_tms[ei] = b; ei++; end
  endtask

  task automatic build_exp();
    ei = 0;
    add(1, 5);                                   // reset
    add(0, 1); add(1, 2); add(0, 2);             // to Shift-IR
    add(0, 5); add(1, 1);                        // IR
    add(1, 2); add(0, 2);                        // to Shift-DR
    add(0, 127); add(1, 1);                      // write pass
    add(1, 3); add(0, 2);                        // to Shift-IR
    add(0, 5); add(1, 1);                        // IR
    add(1, 2); add(0, 2);                        // to Shift-DR
    add(0, 31); add(1, 1);                       // read pass
    add(1, 5);                                   // final reset
  endtask

  task automatic seg(int base, int lo, int len, string tag);
    int bad_at = -1;
    for (int k = 0; k < len; k++)
      if (bad_at < 0 && tms_hist[base + lo + k] != exp_tms[lo + k]) bad_at = lo + k;
    if (bad_at < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s tms step %0d", tag, bad_at),
             64'(tms_hist[base + bad_at]), 64'(exp_tms[bad_at]));
  endtask

  task automatic run_txn(logic [31:0] hdr, logic [31:0] val, tap_e kick, bit poke);
    int br, bi, bw, d0, v0, p0, cyc;
    reg_val = val;
    kick_state = kick;
    tap_kick = 1'b1; #1; tap_kick = 1'b0;
    br = rise_n; bi = ir_n; bw = w_n; d0 = done_n; v0 = viol; p0 = phase_err;
    @(negedge clk); header_i = hdr; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; header_i = $urandom;
    if (poke) begin
      repeat (150) @(negedge clk);
      start_i = 1'b1; header_i = ~hdr;
      @(negedge clk); start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done_o, "R9 done seen", 64'(done_o), 1);
    chk(result_o == val, "R7 result", result_o, val);
    chk(st == TLR, "R8 tap in reset", 64'(st), 64'(TLR));
    chk(rise_n - br == 200, "R11 tck count", rise_n - br, 200);
    chk(ir_n - bi == 2, "R4 instr count", ir_n - bi, 2);
    chk(ir_hist[bi] == 6'b000101, "R4 cfg in code", ir_hist[bi], 6'b000101);
    chk(ir_hist[bi + 1] == 6'b000100, "R4 cfg out code", ir_hist[bi + 1], 6'b000100);
    chk(w_n - bw == 4, "R6 word count", w_n - bw, 4);
    chk(w_hist[bw] == SYNC, "R6 sync word", w_hist[bw], SYNC);
    chk(w_hist[bw + 1] == hdr, "R6 R10 header word", w_hist[bw + 1], hdr);
    chk(w_hist[bw + 2] == NOOP, "R6 flush 1", w_hist[bw + 2], NOOP);
    chk(w_hist[bw + 3] == NOOP, "R6 flush 2", w_hist[bw + 3], NOOP);
    seg(br, 0, 5, "R3 reset");
    seg(br, 5, 5, "R3 walk to IR");
    seg(br, 10, 6, "R4 ir shift");
    seg(br, 16, 4, "R5 walk to DR");
    seg(br, 20, 128, "R6 write pass");
    seg(br, 148, 5, "R7 walk to IR");
    seg(br, 153, 6, "R4 ir shift 2");
    seg(br, 159, 4, "R5 walk to DR 2");
    seg(br, 163, 32, "R7 read pass");
    seg(br, 195, 5, "R8 final reset");
    chk(viol == v0, "R2 pins moved with tck high", viol - v0, 0);
    chk(phase_err == p0, "R1 tck phase length", phase_err - p0, 0);
    @(negedge clk);
    chk(!done_o, "R9 done width", 64'(done_o), 0);
    repeat (10) @(negedge clk);
    chk(result_o == val, "R9 result hold", result_o, val);
    chk(done_n - d0 == 1, "R10 R9 single done", done_n - d0, 1);
    chk(!tck_o, "R1 tck idle", 64'(tck_o), 0);
  endtask

  initial begin
    tap_e kicks [0:4];
    kicks[0] = TLR; kicks[1] = RTI; kicks[2] = SHDR; kicks[3] = E2DR; kicks[4] = SDS;
    void'($urandom(32'h1D5EED));
    build_exp();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tck_o && !done_o, "R1 reset tck/done", {tck_o, done_o}, 0);
    chk(tms_o && !tdi_o, "R2 reset tms/tdi", {tms_o, tdi_o}, 2'b10);
    run_txn(32'h2800E001, 32'hFFFFFFFF, TLR, 1'b0);
    run_txn(32'h00000000, 32'h00000000, SHDR, 1'b0);
    run_txn(32'hFFFFFFFF, 32'h80000001, RTI, 1'b1);
    for (int n = 0; n < 6; n++)
      run_txn($urandom, $urandom, kicks[$urandom % 5], n[0]);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule